// File: doc/BRIEF.md
# Reset Sequencer and Source Identifier

This block produces the chip-wide reset level and decides which start address the processor loads when reset ends. After power becomes good, it waits a fixed number of oscillator cycles so the clock generator can settle. On every reset it then pulls the shared open-drain reset pad low for a short fixed pulse, lets the pad go, waits a short fixed time, and reads the pad level back through a synchronizer. If the pad is still low, something outside the chip is holding it, and the reset is external. If the pad is high, the reset was raised inside the chip. In that case a clock-monitor fault is checked first, then a watchdog timeout, and the normal start address is the fallback.

Internal causes are latched when they occur. A clock-monitor fault counts only while its enable input is high. The latches are cleared on the edge that chooses the vector. When reset is released, the chosen address and the S, X and I mask bits (all set) are presented for a fetch window of a few cycles.

The pad is modelled as two signals at the pad cell: `pin_in` is the level read from the pad and `pin_pull` enables the pull-down. Power-good low acts as the synchronous, active-high-effect reset of all state.

Top module: `rst_seq_core`

## Requirements
- R1: While `pwr_good` is low, `sys_rst`=1, `pin_pull`=0 and `fetch_active`=0. After `pwr_good` rises, `pin_pull` first reads 1 after exactly POR_CYCLES (4064) rising clock edges, and `sys_rst` stays 1 throughout.
- R2: In each reset sequence, `pin_pull` is 1 for exactly STRETCH (4) consecutive cycles, and `sys_rst` is 1 for all of them.
- R3: The pad is read through a SYNC_STAGES (2) flop synchronizer. The choice is made SAMPLE_DLY+SYNC_STAGES (4) cycles after `pin_pull` falls. If the pad is still low at that point, the vector is 0xFFFE (external), whatever causes are pending.
- R4: If the pad reads high and a clock-monitor fault is pending, the vector is 0xFFFC. This holds even when a watchdog timeout is pending at the same time.
- R5: If the pad reads high, no clock-monitor fault is pending and a watchdog timeout is pending, the vector is 0xFFFA.
- R6: If the pad reads high and no internal cause is pending (for example after power-up), the normal vector 0xFFFE is chosen.
- R7: While `cm_en`=0, `cm_fault` has no effect: no sequence starts, so `sys_rst` and `pin_pull` stay 0.
- R8: `sys_rst` falls on the same edge that `fetch_active` rises. `fetch_active` then stays 1 for exactly FETCH_CYCLES (3) cycles, with `vec_addr` held stable and `ccr_sxi`=3'b111 (bit 2 S, bit 1 X, bit 0 I).
- R9: Pending internal causes are cleared when the vector is chosen. A later brief external pulse on the pad therefore yields 0xFFFE, not the earlier cause's vector.
- R10: In the run state, a one-cycle `wd_req` pulse drives `sys_rst` to 1 on the second rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock (E-clock rate) |
| pwr_good | input | 1 | Power good; low resets all state |
| pin_in | input | 1 | Level read from the open-drain reset pad |
| cm_en | input | 1 | Enable for clock-monitor faults |
| cm_fault | input | 1 | Clock-monitor detector: clock too slow |
| wd_req | input | 1 | Watchdog timeout request |
| sys_rst | output | 1 | Internal reset level, active high |
| pin_pull | output | 1 | Pull-down enable for the reset pad |
| vec_addr | output | ADDR_W | Selected reset vector address |
| ccr_sxi | output | 3 | Reset values of S, X, I mask bits |
| fetch_active | output | 1 | High during the vector fetch window |

## Verification
The assertions check on every cycle that:
- the pull pulse has the right length and falls only inside reset;
- reset ends exactly where the fetch window starts;
- the mask bits are set and the vector is stable and legal during the fetch window.

Only the bench scenarios can show that:
- the right vector comes out of the priority between the pad level, clock-monitor and watchdog;
- the clock-monitor enable gates faults;
- latches are cleared after each choice, so a short external pulse falls back to the normal vector;
- the power-up delay lasts the stated number of cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR    = 3'd0,
    ST_PULL   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_FETCH  = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;

  localparam int CAUSE_CMON = 0;
  localparam int CAUSE_WDOG = 1;
  localparam int NUM_CAUSES = 2;

  // Priority: pad held low, then clock monitor, then watchdog, then normal.
  function automatic logic [15:0] pick_vector(
    input logic        pad_high,
    input logic        cm_pend,
    input logic        wd_pend,
    input logic [15:0] v_ext,
    input logic [15:0] v_cmon,
    input logic [15:0] v_wdog,
    input logic [15:0] v_norm
  );
    if (!pad_high)    return v_ext;
    else if (cm_pend) return v_cmon;
    else if (wd_pend) return v_wdog;
    else              return v_norm;
  endfunction

endpackage

// File: rtl/rst_pad_sync.sv
module rst_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic pad_raw,
  output logic pad_sync
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!pwr_good) shreg <= '1;
    else           shreg <= {shreg[STAGES-2:0], pad_raw};
  end

  assign pad_sync = shreg[STAGES-1];
endmodule

// File: rtl/rst_cause_latch.sv
module rst_cause_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         pwr_good,
  input  logic [N-1:0] set_evt,
  input  logic         clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!pwr_good) pend[i] <= 1'b0;
      else           pend[i] <= (pend[i] & ~clr) | set_evt[i];
    end
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int          POR_CYCLES   = 4064,
  parameter int          STRETCH      = 4,
  parameter int          SETTLE_CYC   = 4,
  parameter int          FETCH_CYCLES = 3,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] VEC_EXT      = 16'hFFFE,
  parameter logic [15:0] VEC_CMON     = 16'hFFFC,
  parameter logic [15:0] VEC_WDOG     = 16'hFFFA,
  parameter logic [15:0] VEC_NORM     = 16'hFFFE
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              pad_sync,
  input  logic              cm_pend,
  input  logic              wd_pend,
  output logic              clr_pend,
  output logic              sys_rst,
  output logic              pin_pull,
  output logic              fetch_active,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [2:0]        ccr_sxi
);
  localparam int MAX_A = (POR_CYCLES > STRETCH) ? POR_CYCLES : STRETCH;
  localparam int MAX_B = (SETTLE_CYC > FETCH_CYCLES) ? SETTLE_CYC : FETCH_CYCLES;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             at_lim;
  logic             decide;
  logic             trig;

  always_comb begin
    case (st)
      ST_POR:    lim = CNT_W'(POR_CYCLES - 1);
      ST_PULL:   lim = CNT_W'(STRETCH - 1);
      ST_SETTLE: lim = CNT_W'(SETTLE_CYC - 1);
      ST_FETCH:  lim = CNT_W'(FETCH_CYCLES - 1);
      default:   lim = '0;
    endcase
    at_lim = (cnt == lim);
    decide = (st == ST_SETTLE) && at_lim;
    trig   = !pad_sync || cm_pend || wd_pend;
  end

  assign clr_pend = decide;

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      st           <= ST_POR;
      cnt          <= '0;
      sys_rst      <= 1'b1;
      pin_pull     <= 1'b0;
      fetch_active <= 1'b0;
      vec_addr     <= ADDR_W'(VEC_NORM);
      ccr_sxi      <= 3'b000;
    end else begin
      case (st)
        ST_POR: begin
          if (at_lim) begin
            st       <= ST_PULL;
            cnt      <= '0;
            pin_pull <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PULL: begin
          if (at_lim) begin
            st       <= ST_SETTLE;
            cnt      <= '0;
            pin_pull <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (at_lim) begin
            st           <= ST_FETCH;
            cnt          <= '0;
            sys_rst      <= 1'b0;
            fetch_active <= 1'b1;
            ccr_sxi      <= 3'b111;
            vec_addr     <= ADDR_W'(pick_vector(pad_sync, cm_pend, wd_pend,
                                                VEC_EXT, VEC_CMON, VEC_WDOG, VEC_NORM));
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FETCH: begin
          if (at_lim) begin
            st           <= ST_RUN;
            cnt          <= '0;
            fetch_active <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (trig) begin
            st       <= ST_PULL;
            cnt      <= '0;
            sys_rst  <= 1'b1;
            pin_pull <= 1'b1;
          end
        end
        default: begin
          st  <= ST_POR;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rst_seq_core.sv
module rst_seq_core
  import rst_seq_pkg::*;
#(
  parameter int          POR_CYCLES   = 4064,
  parameter int          STRETCH      = 4,
  parameter int          SAMPLE_DLY   = 2,
  parameter int          SYNC_STAGES  = 2,
  parameter int          FETCH_CYCLES = 3,
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] VEC_EXT      = 16'hFFFE,
  parameter logic [15:0] VEC_CMON     = 16'hFFFC,
  parameter logic [15:0] VEC_WDOG     = 16'hFFFA,
  parameter logic [15:0] VEC_NORM     = 16'hFFFE
) (
  input  logic              clk,
  input  logic              pwr_good,
  input  logic              pin_in,
  input  logic              cm_en,
  input  logic              cm_fault,
  input  logic              wd_req,
  output logic              sys_rst,
  output logic              pin_pull,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [2:0]        ccr_sxi,
  output logic              fetch_active
);
  localparam int SETTLE_CYC = SAMPLE_DLY + SYNC_STAGES;

  logic                  pad_sync;
  logic                  clr_pend;
  logic [NUM_CAUSES-1:0] cause_set;
  logic [NUM_CAUSES-1:0] cause_pend;

  always_comb begin
    cause_set             = '0;
    cause_set[CAUSE_CMON] = cm_en & cm_fault;
    cause_set[CAUSE_WDOG] = wd_req;
  end

  rst_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .pwr_good (pwr_good),
    .pad_raw  (pin_in),
    .pad_sync (pad_sync)
  );

  rst_cause_latch #(.N(NUM_CAUSES)) u_cause (
    .clk      (clk),
    .pwr_good (pwr_good),
    .set_evt  (cause_set),
    .clr      (clr_pend),
    .pend     (cause_pend)
  );

  rst_seq_fsm #(
    .POR_CYCLES   (POR_CYCLES),
    .STRETCH      (STRETCH),
    .SETTLE_CYC   (SETTLE_CYC),
    .FETCH_CYCLES (FETCH_CYCLES),
    .ADDR_W       (ADDR_W),
    .VEC_EXT      (VEC_EXT),
    .VEC_CMON     (VEC_CMON),
    .VEC_WDOG     (VEC_WDOG),
    .VEC_NORM     (VEC_NORM)
  ) u_fsm (
    .clk          (clk),
    .pwr_good     (pwr_good),
    .pad_sync     (pad_sync),
    .cm_pend      (cause_pend[CAUSE_CMON]),
    .wd_pend      (cause_pend[CAUSE_WDOG]),
    .clr_pend     (clr_pend),
    .sys_rst      (sys_rst),
    .pin_pull     (pin_pull),
    .fetch_active (fetch_active),
    .vec_addr     (vec_addr),
    .ccr_sxi      (ccr_sxi)
  );
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int          STRETCH  = 4,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_EXT  = 16'hFFFE,
  parameter logic [15:0] VEC_CMON = 16'hFFFC,
  parameter logic [15:0] VEC_WDOG = 16'hFFFA,
  parameter logic [15:0] VEC_NORM = 16'hFFFE
) (
  input logic              clk,
  input logic              pwr_good,
  input logic              sys_rst,
  input logic              pin_pull,
  input logic              fetch_active,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [2:0]        ccr_sxi
);
  localparam int LW = $clog2(STRETCH + 2);
  logic [LW-1:0] pull_len;

  always_ff @(posedge clk) begin
    if (!pwr_good)     pull_len <= '0;
    else if (pin_pull) pull_len <= (pull_len == LW'(STRETCH + 1)) ? pull_len : pull_len + 1'b1;
    else               pull_len <= '0;
  end

  // R2
  pull_len_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(pin_pull) |-> (pull_len == LW'(STRETCH)));

  // R2
  pull_in_rst_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    pin_pull |-> sys_rst);

  // R8
  rel_starts_fetch_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(sys_rst) |-> fetch_active);

  // R8
  fetch_masks_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    fetch_active |-> (ccr_sxi == 3'b111 && !sys_rst));

  // R8
  fetch_vec_stable_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (fetch_active && $past(fetch_active)) |-> $stable(vec_addr));

  // R3
  vec_legal_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    fetch_active |-> (vec_addr == ADDR_W'(VEC_EXT) || vec_addr == ADDR_W'(VEC_CMON) ||
                      vec_addr == ADDR_W'(VEC_WDOG) || vec_addr == ADDR_W'(VEC_NORM)));
endmodule

bind rst_seq_core rst_seq_chk #(
  .STRETCH  (STRETCH),
  .ADDR_W   (ADDR_W),
  .VEC_EXT  (VEC_EXT),
  .VEC_CMON (VEC_CMON),
  .VEC_WDOG (VEC_WDOG),
  .VEC_NORM (VEC_NORM)
) u_rst_seq_chk (
  .clk          (clk),
  .pwr_good     (pwr_good),
  .sys_rst      (sys_rst),
  .pin_pull     (pin_pull),
  .fetch_active (fetch_active),
  .vec_addr     (vec_addr),
  .ccr_sxi      (ccr_sxi)
);

// File: tb/rst_seq_core_bench.sv
module rst_seq_core_bench;
  localparam int POR_CYCLES = 4064;
  localparam int STRETCH    = 4;
  localparam int SETTLE     = 4;
  localparam int FETCH      = 3;

  logic        clk = 1'b0;
  logic        pwr_good, btn, cm_en, cm_fault, wd_req;
  logic        pin_in;
  logic        sys_rst, pin_pull, fetch_active;
  logic [15:0] vec_addr;
  logic [2:0]  ccr_sxi;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  // Open-drain pad: low if the block pulls or the outside button holds it.
  assign pin_in = ~pin_pull & ~btn;

  rst_seq_core u_rst_seq_core (
    .clk(clk), .pwr_good(pwr_good), .pin_in(pin_in), .cm_en(cm_en),
    .cm_fault(cm_fault), .wd_req(wd_req), .sys_rst(sys_rst), .pin_pull(pin_pull),
    .vec_addr(vec_addr), .ccr_sxi(ccr_sxi), .fetch_active(fetch_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  // Monitor: sequence timing and scoreboard of vectors
  logic prev_pull = 0, prev_fetch = 0, in_gap = 0;
  int   pull_run = 0, gap = 0, fetch_run = 0;
  always @(negedge clk) begin
    if (pwr_good) begin
      if (pin_pull) pull_run++;
      if (prev_pull && !pin_pull) begin
        chk("R2 pull length", pull_run, STRETCH);
        pull_run = 0; gap = 1; in_gap = 1;
      end else if (in_gap && !fetch_active) gap++;
      if (fetch_active && !prev_fetch) begin
        in_gap = 0;
        chk("R3 release-to-decision cycles", gap, SETTLE);
        chk("R8 sys_rst low at fetch start", sys_rst, 0);
        chk("R8 ccr_sxi", ccr_sxi, 3'b111);
        if (exp_q.size() == 0) chk("R3 unexpected vector", vec_addr, 16'h0);
        else chk("R3-R6 vector", vec_addr, exp_q.pop_front());
        fetch_run = 0;
      end
      if (fetch_active) fetch_run++;
      if (prev_fetch && !fetch_active) begin
        chk("R8 fetch window", fetch_run, FETCH);
        done_cnt++;
      end
      prev_pull = pin_pull; prev_fetch = fetch_active;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int por;
    pwr_good = 0; btn = 0; cm_en = 0; cm_fault = 0; wd_req = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset sys_rst", sys_rst, 1);
    chk("R1 reset pin_pull", pin_pull, 0);
    chk("R1 reset fetch_active", fetch_active, 0);

    // R6 power-up, no pending cause
    exp_q.push_back(16'hFFFE);
    pwr_good = 1;
    por = 0;
    do begin @(negedge clk); por++; if (!sys_rst) chk("R1 sys_rst during delay", sys_rst, 1); end
    while (!pin_pull && por < 5000);
    chk("R1 power-up delay", por, POR_CYCLES);
    wait_done(1);

    // R5 watchdog, R10 reset entry timing
    repeat (5) @(negedge clk);
    exp_q.push_back(16'hFFFA);
    wd_req = 1;
    @(negedge clk); wd_req = 0;
    @(negedge clk);
    chk("R10 sys_rst after watchdog", sys_rst, 1);
    wait_done(2);

    // R7 disabled clock monitor ignored
    repeat (5) @(negedge clk);
    cm_fault = 1;
    repeat (20) @(negedge clk);
    chk("R7 sys_rst with cm disabled", sys_rst, 0);
    chk("R7 pin_pull with cm disabled", pin_pull, 0);
    chk("R7 no sequence", done_cnt, 2);
    cm_fault = 0;

    // R4 clock monitor
    @(negedge clk); cm_en = 1; cm_fault = 1;
    exp_q.push_back(16'hFFFC);
    @(negedge clk); cm_fault = 0;
    wait_done(3);

    // R4 clock monitor beats watchdog
    repeat (5) @(negedge clk);
    exp_q.push_back(16'hFFFC);
    cm_fault = 1; wd_req = 1;
    @(negedge clk); cm_fault = 0; wd_req = 0;
    wait_done(4);

    // R3 pad held low beats clock monitor
    repeat (5) @(negedge clk);
    exp_q.push_back(16'hFFFE);
    btn = 1; cm_fault = 1;
    @(negedge clk); cm_fault = 0;
    while (!fetch_active) @(negedge clk);
    btn = 0;
    wait_done(5);

    // R9 pending cleared: watchdog, then short pad pulse
    repeat (5) @(negedge clk);
    exp_q.push_back(16'hFFFA);
    wd_req = 1;
    @(negedge clk); wd_req = 0;
    wait_done(6);
    repeat (5) @(negedge clk);
    exp_q.push_back(16'hFFFE);
    btn = 1;
    repeat (2) @(negedge clk);
    btn = 0;
    wait_done(7);

    repeat (10) @(negedge clk);
    chk("R9 idle after sequences", sys_rst, 0);
    chk("R3 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule